// File: doc/BRIEF.md
# Serial Flash Status Register Write Path

This block is the slave-side command logic of a serial flash that lets a host rewrite its 24-bit status register. It runs on a system clock. It brings the serial clock, chip select, protect pin and data lines into that domain and counts the bits of each chip-select frame. Data is shifted in on the rising serial-clock edge, one bit per edge on dq_i[0], or one nibble per edge on dq_i[3:0] when the four-line mode is selected.

A status write uses one of three opcodes, and the opcode picks which byte of the register is written. The write takes effect only if all of the following hold:
- a separately framed write-enable command has set the write-enable latch;
- chip select rises exactly after the data byte;
- no self-timed cycle is running;
- the lock bit together with the protect pin does not select hardware protection.

An accepted write starts a busy period counted in system clocks. The latch clears when that period ends.

Three read opcodes stream one status byte repeatedly while chip select stays low. Each repeat is re-sampled, so the host can poll the busy flag inside one frame.

Top module: `sfsr_writer`

## Requirements
- R1: After reset all three status bytes read 0x00 and dq_oe is 0.
- R2: Opcode 0x06 sets the write-enable latch (status bit 1) only when chip select rises after exactly 8 bits. Rising after 7 or 9 bits leaves the latch unchanged.
- R3: When accepted, opcodes 0x01, 0x31 and 0x11 write the following data byte, MSB first, into status bits 7..0, 15..8 and 23..16 respectively.
- R4: A status write issued while the write-enable latch is clear changes nothing.
- R5: A status write whose frame ends at any bit count other than 16 is discarded, and the write-enable latch stays set.
- R6: An accepted write sets the busy flag (status bit 0) for TW_CYCLES system clocks starting at the chip-select rise. When the busy flag falls, the write-enable latch clears with it.
- R7: Bits 0 and 1 carry only the busy flag and the latch. Bits 10, 15, 16, 17, 19 and 20 are never written and read 0, so writing 0xFF gives 0xFC, 0x7B and 0xE4 on the low, middle and high bytes.
- R8: With bit 7 = 1, bit 8 = 0 and wp_n low, a status write is ignored and the latch stays set. With wp_n high the same write is accepted.
- R9: Opcodes 0x05, 0x35 and 0x15 return the low, middle and high byte MSB first on dq_o[1], with dq_oe = 0010. The byte is output from the falling edge after the opcode and repeats while chip select is low, each repeat re-sampled so the busy flag can be seen clearing.
- R10: With qpi_en high, opcodes and data take two cycles each, high nibble first on dq_i[3:0]. Reads return nibbles, high first, on dq_o[3:0] with dq_oe = 1111. A write ends after 16 bits, which is 4 nibbles.
- R11: A write-enable or status-write frame that ends while the busy flag is set is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| qpi_en | input | 1 | 1 selects four-line nibble transfers |
| sclk | input | 1 | Serial clock, idles low |
| cs_n | input | 1 | Active-low chip select |
| wp_n | input | 1 | Active-low write-protect pin |
| dq_i | input | 4 | Serial data in (bit 0 in single-line mode) |
| dq_o | output | 4 | Serial data out (bit 1 in single-line mode) |
| dq_oe | output | 4 | Output enables for dq_o |

## Verification
The hardest state to reach is a frame that ends during the busy period. The write must first be accepted, and then a second write-enable and status-write pair must be framed completely before TW_CYCLES elapse. The bench raises TW_CYCLES so that several whole frames fit into the busy period, and sends those frames right after the accepted write. Hardware protection also needs a particular register history: the lock bit in the middle byte is cleared, the low-byte lock bit is set, and only then is wp_n lowered.

// File: rtl/sfsr_pkg.sv
package sfsr_pkg;
    localparam int SR_BITS = 24;

    localparam logic [7:0] OP_WR_ENABLE = 8'h06;
    localparam logic [7:0] OP_WR_LO     = 8'h01;
    localparam logic [7:0] OP_WR_MID    = 8'h31;
    localparam logic [7:0] OP_WR_HI     = 8'h11;
    localparam logic [7:0] OP_RD_LO     = 8'h05;
    localparam logic [7:0] OP_RD_MID    = 8'h35;
    localparam logic [7:0] OP_RD_HI     = 8'h15;

    localparam int LOCK_LO_BIT = 7;
    localparam int LOCK_HI_BIT = 8;

    localparam logic [SR_BITS-1:0] SR_FLAG_BITS  = SR_BITS'(3);
    localparam logic [SR_BITS-1:0] SR_FIXED_BITS =
        (SR_BITS'(1) << 20) | (SR_BITS'(1) << 19) | (SR_BITS'(1) << 17) |
        (SR_BITS'(1) << 16) | (SR_BITS'(1) << 15) | (SR_BITS'(1) << 10);
    localparam logic [SR_BITS-1:0] SR_WRITABLE = ~(SR_FLAG_BITS | SR_FIXED_BITS);

    typedef enum logic [1:0] {LANE_LO, LANE_MID, LANE_HI, LANE_NONE} lane_e;

    function automatic lane_e write_lane(input logic [7:0] op);
        case (op)
            OP_WR_LO:  return LANE_LO;
            OP_WR_MID: return LANE_MID;
            OP_WR_HI:  return LANE_HI;
            default:   return LANE_NONE;
        endcase
    endfunction

    function automatic lane_e read_lane(input logic [7:0] op);
        case (op)
            OP_RD_LO:  return LANE_LO;
            OP_RD_MID: return LANE_MID;
            OP_RD_HI:  return LANE_HI;
            default:   return LANE_NONE;
        endcase
    endfunction

    function automatic logic [SR_BITS-1:0] lane_mask(input lane_e lane);
        case (lane)
            LANE_LO:  return SR_BITS'(24'h0000FF);
            LANE_MID: return SR_BITS'(24'h00FF00);
            LANE_HI:  return SR_BITS'(24'hFF0000);
            default:  return '0;
        endcase
    endfunction

    function automatic logic [7:0] lane_byte(input logic [SR_BITS-1:0] sr, input lane_e lane);
        case (lane)
            LANE_LO:  return sr[7:0];
            LANE_MID: return sr[15:8];
            LANE_HI:  return sr[23:16];
            default:  return 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/sfsr_sync.sv
module sfsr_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
        else        pipe_q <= pipe_d;
    end

    assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/sfsr_frame.sv
module sfsr_frame #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             qpi_en,
    input  logic             sclk_s,
    input  logic             cs_n_s,
    input  logic [3:0]       dq_s,
    output logic             sclk_fall,
    output logic             op_done,
    output logic [7:0]       op_now,
    output logic [7:0]       op_q,
    output logic [7:0]       data_q,
    output logic             frame_end,
    output logic [CNT_W-1:0] frame_bits
);
    localparam logic [CNT_W-1:0] CNT_MAX   = '1;
    localparam logic [CNT_W-1:0] OP_BITS   = CNT_W'(8);
    localparam logic [CNT_W-1:0] DATA_BITS = CNT_W'(16);

    typedef struct packed {
        logic             sclk_prev;
        logic             cs_prev;
        logic [CNT_W-1:0] cnt;
        logic [7:0]       sh;
        logic [7:0]       op;
        logic [7:0]       data;
    } frame_t;

    frame_t st_d, st_q;
    logic             rise;
    logic [CNT_W-1:0] step;
    logic [CNT_W-1:0] cnt_next;
    logic [7:0]       sh_next;

    always_comb begin
        st_d           = st_q;
        st_d.sclk_prev = sclk_s;
        st_d.cs_prev   = cs_n_s;
        rise      = sclk_s & ~st_q.sclk_prev & ~cs_n_s;
        sclk_fall = ~sclk_s & st_q.sclk_prev & ~cs_n_s;
        frame_end = cs_n_s & ~st_q.cs_prev;
        step      = qpi_en ? CNT_W'(4) : CNT_W'(1);
        sh_next   = qpi_en ? {st_q.sh[3:0], dq_s} : {st_q.sh[6:0], dq_s[0]};
        cnt_next  = (st_q.cnt > CNT_MAX - step) ? CNT_MAX : st_q.cnt + step;
        op_done   = 1'b0;
        if (!cs_n_s && st_q.cs_prev) begin
            st_d.cnt = '0;
            st_d.sh  = '0;
        end else if (rise) begin
            st_d.sh  = sh_next;
            st_d.cnt = cnt_next;
            if (cnt_next == OP_BITS) begin
                st_d.op = sh_next;
                op_done = 1'b1;
            end
            if (cnt_next == DATA_BITS) st_d.data = sh_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.sclk_prev <= 1'b0;
            st_q.cs_prev   <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign op_now     = sh_next;
    assign op_q       = st_q.op;
    assign data_q     = st_q.data;
    assign frame_bits = st_q.cnt;
endmodule

// File: rtl/sfsr_status.sv
module sfsr_status
    import sfsr_pkg::*;
#(
    parameter int TW_CYCLES = 256,
    parameter int CNT_W     = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_end,
    input  logic [CNT_W-1:0]   frame_bits,
    input  logic [7:0]         op_q,
    input  logic [7:0]         data_q,
    input  logic               wp_n_s,
    output logic [SR_BITS-1:0] sr_view,
    output logic               busy,
    output logic               wlatch
);
    localparam int TW_W = $clog2(TW_CYCLES + 1);

    typedef struct packed {
        logic [SR_BITS-1:0] sr;
        logic               wlatch;
        logic               busy;
        logic [TW_W-1:0]    timer;
    } status_t;

    status_t            st_d, st_q;
    lane_e              lane;
    logic               hw_lock;
    logic               enable_ok;
    logic               write_ok;
    logic [SR_BITS-1:0] sel_mask;
    logic [SR_BITS-1:0] placed;

    always_comb begin
        st_d      = st_q;
        lane      = write_lane(op_q);
        hw_lock   = st_q.sr[LOCK_LO_BIT] & ~st_q.sr[LOCK_HI_BIT] & ~wp_n_s;
        enable_ok = frame_end && (op_q == OP_WR_ENABLE) && (frame_bits == CNT_W'(8));
        write_ok  = frame_end && (lane != LANE_NONE) && (frame_bits == CNT_W'(16))
                    && st_q.wlatch && !hw_lock;
        sel_mask  = lane_mask(lane) & SR_WRITABLE;
        placed    = {data_q, data_q, data_q} & sel_mask;
        if (st_q.busy) begin
            if (st_q.timer == TW_W'(1)) begin
                st_d.busy   = 1'b0;
                st_d.wlatch = 1'b0;
                st_d.timer  = '0;
            end else begin
                st_d.timer = st_q.timer - TW_W'(1);
            end
        end else if (write_ok) begin
            st_d.sr    = (st_q.sr & ~sel_mask) | placed;
            st_d.busy  = 1'b1;
            st_d.timer = TW_W'(TW_CYCLES);
        end else if (enable_ok) begin
            st_d.wlatch = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy    = st_q.busy;
    assign wlatch  = st_q.wlatch;
    assign sr_view = (st_q.sr & ~SR_FLAG_BITS) | {{(SR_BITS-2){1'b0}}, st_q.wlatch, st_q.busy};
endmodule

// File: rtl/sfsr_readout.sv
module sfsr_readout
    import sfsr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               qpi_en,
    input  logic               cs_n_s,
    input  logic               sclk_fall,
    input  logic               op_done,
    input  logic [7:0]         op_now,
    input  logic [SR_BITS-1:0] sr_view,
    output logic [3:0]         dq_o,
    output logic [3:0]         dq_oe
);
    typedef struct packed {
        logic       active;
        logic       first;
        logic [2:0] idx;
        logic [7:0] snap;
        lane_e      lane;
    } rd_t;

    rd_t        st_d, st_q;
    lane_e      new_lane;
    logic [2:0] last_idx;

    always_comb begin
        st_d     = st_q;
        new_lane = read_lane(op_now);
        last_idx = qpi_en ? 3'd3 : 3'd0;
        if (cs_n_s) begin
            st_d.active = 1'b0;
            st_d.first  = 1'b0;
        end else if (op_done && new_lane != LANE_NONE) begin
            st_d.active = 1'b1;
            st_d.first  = 1'b1;
            st_d.idx    = 3'd7;
            st_d.lane   = new_lane;
            st_d.snap   = lane_byte(sr_view, new_lane);
        end else if (sclk_fall && st_q.active) begin
            if (st_q.first) begin
                st_d.first = 1'b0;
            end else if (st_q.idx == last_idx) begin
                st_d.idx  = 3'd7;
                st_d.snap = lane_byte(sr_view, st_q.lane);
            end else begin
                st_d.idx = st_q.idx - (qpi_en ? 3'd4 : 3'd1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.lane <= LANE_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        dq_o  = 4'b0000;
        dq_oe = 4'b0000;
        if (st_q.active) begin
            if (qpi_en) begin
                dq_o  = st_q.idx[2] ? st_q.snap[7:4] : st_q.snap[3:0];
                dq_oe = 4'b1111;
            end else begin
                dq_o  = {2'b00, st_q.snap[st_q.idx], 1'b0};
                dq_oe = 4'b0010;
            end
        end
    end
endmodule

// File: rtl/sfsr_writer.sv
module sfsr_writer
    import sfsr_pkg::*;
#(
    parameter int TW_CYCLES   = 256,
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       qpi_en,
    input  logic       sclk,
    input  logic       cs_n,
    input  logic       wp_n,
    input  logic [3:0] dq_i,
    output logic [3:0] dq_o,
    output logic [3:0] dq_oe
);
    localparam int PIN_W = 7;

    logic [PIN_W-1:0]   pins_s;
    logic               sclk_s, cs_n_s, wp_n_s;
    logic [3:0]         dq_s;
    logic               sclk_fall, op_done, frame_end;
    logic [7:0]         op_now, op_q, data_q;
    logic [CNT_W-1:0]   frame_bits;
    logic [SR_BITS-1:0] sr_view;
    logic               busy, wlatch;

    sfsr_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(7'b1100000)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({wp_n, cs_n, sclk, dq_i}),
        .q(pins_s)
    );
    assign {wp_n_s, cs_n_s, sclk_s, dq_s} = pins_s;

    sfsr_frame #(.CNT_W(CNT_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .qpi_en(qpi_en),
        .sclk_s(sclk_s), .cs_n_s(cs_n_s), .dq_s(dq_s),
        .sclk_fall(sclk_fall), .op_done(op_done), .op_now(op_now),
        .op_q(op_q), .data_q(data_q),
        .frame_end(frame_end), .frame_bits(frame_bits)
    );

    sfsr_status #(.TW_CYCLES(TW_CYCLES), .CNT_W(CNT_W)) u_status (
        .clk(clk), .rst_n(rst_n),
        .frame_end(frame_end), .frame_bits(frame_bits),
        .op_q(op_q), .data_q(data_q), .wp_n_s(wp_n_s),
        .sr_view(sr_view), .busy(busy), .wlatch(wlatch)
    );

    sfsr_readout u_readout (
        .clk(clk), .rst_n(rst_n), .qpi_en(qpi_en),
        .cs_n_s(cs_n_s), .sclk_fall(sclk_fall),
        .op_done(op_done), .op_now(op_now), .sr_view(sr_view),
        .dq_o(dq_o), .dq_oe(dq_oe)
    );
endmodule

// File: rtl/sfsr_checker.sv
module sfsr_checker
    import sfsr_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               busy,
    input logic               wlatch,
    input logic               frame_end,
    input logic [SR_BITS-1:0] sr_view,
    input logic [3:0]         dq_oe
);
    // R6: the latch drops in the same cycle the busy flag falls
    a_r6_latch_clears_with_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !wlatch);

    // R11: stored bits do not move during an ongoing busy period
    a_r11_busy_freezes_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(sr_view[SR_BITS-1:2]));

    // R4: a register change needs the latch set beforehand and starts busy
    a_r4_change_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sr_view[SR_BITS-1:2]) |-> ($past(wlatch) && busy));

    // R2: the latch is only set by the end of a frame
    a_r2_latch_set_at_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wlatch) |-> $past(frame_end));

    // R7: fixed bits always read zero
    a_r7_fixed_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_view & SR_FIXED_BITS) == '0);

    // R9, R10: output enables take only the idle, single-line or four-line shape
    a_r9_oe_shapes: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe == 4'b0000) || (dq_oe == 4'b0010) || (dq_oe == 4'b1111));
endmodule

bind sfsr_writer sfsr_checker u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .wlatch(wlatch),
    .frame_end(frame_end), .sr_view(sr_view), .dq_oe(dq_oe)
);

// File: tb/tb_sfsr_writer.sv
module tb_sfsr_writer;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;
    localparam int TW         = 1500;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       qpi_en = 1'b0;
    logic       sclk = 1'b0;
    logic       cs_n = 1'b1;
    logic       wp_n = 1'b1;
    logic [3:0] dq_i = 4'h0;
    logic [3:0] dq_o, dq_oe;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [3:0] last_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    sfsr_writer #(.TW_CYCLES(TW)) dut (
        .clk(clk), .rst_n(rst_n), .qpi_en(qpi_en), .sclk(sclk), .cs_n(cs_n),
        .wp_n(wp_n), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
        end
    endtask

    task automatic frame_open();
        cs_n = 1'b0;
        tick(HALF);
    endtask

    task automatic frame_close();
        tick(HALF);
        cs_n = 1'b1;
        tick(2 * HALF);
    endtask

    // n units: bits in single-line mode, nibbles in four-line mode
    task automatic shift_units(input logic [7:0] b, input int n);
        for (int i = 0; i < n; i++) begin
            if (qpi_en) dq_i = (i % 2 == 0) ? b[7:4] : b[3:0];
            else        dq_i = {3'b000, b[7 - (i % 8)]};
            tick(HALF);
            sclk = 1'b1;
            tick(HALF);
            sclk = 1'b0;
        end
    endtask

    task automatic get_byte(output logic [7:0] b);
        int n;
        n = qpi_en ? 2 : 8;
        b = 8'h00;
        for (int i = 0; i < n; i++) begin
            tick(HALF);
            if (qpi_en) b = {b[3:0], dq_o};
            else        b = {b[6:0], dq_o[1]};
            last_oe = dq_oe;
            sclk = 1'b1;
            tick(HALF);
            sclk = 1'b0;
        end
    endtask

    function automatic int unit_count();
        return qpi_en ? 2 : 8;
    endfunction

    task automatic send_enable(input int units);
        frame_open();
        shift_units(8'h06, units);
        frame_close();
    endtask

    task automatic send_write(input logic [7:0] op, input logic [7:0] data, input int data_units);
        frame_open();
        shift_units(op, unit_count());
        shift_units(data, data_units);
        frame_close();
    endtask

    task automatic read_status(input logic [7:0] op, output logic [7:0] b);
        frame_open();
        shift_units(op, unit_count());
        get_byte(b);
        frame_close();
    endtask

    task automatic wait_cycle();
        tick(TW + 100);
    endtask

    task automatic t_reset();
        logic [7:0] b;
        check8("R1 oe after reset", {4'h0, dq_oe}, 8'h00);
        read_status(8'h05, b); check8("R1 low byte", b, 8'h00);
        read_status(8'h35, b); check8("R1 mid byte", b, 8'h00);
        read_status(8'h15, b); check8("R1 high byte", b, 8'h00);
    endtask

    task automatic t_no_latch();
        logic [7:0] b;
        send_write(8'h01, 8'hFF, 8);
        tick(10);
        read_status(8'h05, b); check8("R4 write without latch", b, 8'h00);
    endtask

    task automatic t_enable_counts();
        logic [7:0] b;
        send_enable(7);
        read_status(8'h05, b); check8("R2 enable 7 bits", b, 8'h00);
        send_enable(9);
        read_status(8'h05, b); check8("R2 enable 9 bits", b, 8'h00);
        send_enable(8);
        read_status(8'h05, b); check8("R2 enable 8 bits", b, 8'h02);
        check8("R9 single-line oe", {4'h0, last_oe}, 8'h02);
    endtask

    task automatic t_bad_count();
        logic [7:0] b;
        send_write(8'h01, 8'hFF, 7);
        read_status(8'h05, b); check8("R5 write 15 bits", b, 8'h02);
        send_write(8'h01, 8'hFF, 9);
        read_status(8'h05, b); check8("R5 write 17 bits", b, 8'h02);
    endtask

    task automatic t_write_low_and_poll();
        logic [7:0] b;
        bit cleared;
        send_write(8'h01, 8'h34, 8);
        read_status(8'h05, b); check8("R6 busy right after write", b, 8'h37);
        frame_open();
        shift_units(8'h05, 8);
        cleared = 1'b0;
        for (int k = 0; k < 12 && !cleared; k++) begin
            get_byte(b);
            if (b[0] == 1'b0) cleared = 1'b1;
        end
        frame_close();
        check8("R9 poll saw busy clear", {7'h0, cleared}, 8'h01);
        check8("R9 polled final byte", b, 8'h34);
        read_status(8'h05, b); check8("R6 latch cleared after cycle", b, 8'h34);
    endtask

    task automatic t_all_ones();
        logic [7:0] b;
        send_enable(8); send_write(8'h01, 8'hFF, 8); wait_cycle();
        read_status(8'h05, b); check8("R7 low byte all ones", b, 8'hFC);
        send_enable(8); send_write(8'h31, 8'hFF, 8); wait_cycle();
        read_status(8'h35, b); check8("R3 R7 mid byte all ones", b, 8'h7B);
        send_enable(8); send_write(8'h11, 8'hFF, 8); wait_cycle();
        read_status(8'h15, b); check8("R3 R7 high byte all ones", b, 8'hE4);
    endtask

    task automatic t_busy_ignore();
        logic [7:0] b;
        send_enable(8);
        send_write(8'h31, 8'h00, 8);
        send_enable(8);
        send_write(8'h11, 8'h00, 8);
        wait_cycle();
        read_status(8'h15, b); check8("R11 write during busy ignored", b, 8'hE4);
        read_status(8'h35, b); check8("R3 mid byte cleared", b, 8'h00);
        read_status(8'h05, b); check8("R11 enable during busy ignored", b, 8'hFC);
    endtask

    task automatic t_hw_protect();
        logic [7:0] b;
        wp_n = 1'b0;
        tick(4);
        send_enable(8);
        send_write(8'h01, 8'h00, 8);
        tick(10);
        read_status(8'h05, b); check8("R8 protected write ignored", b, 8'hFE);
        wp_n = 1'b1;
        tick(4);
        send_write(8'h01, 8'h00, 8);
        wait_cycle();
        read_status(8'h05, b); check8("R8 unprotected write accepted", b, 8'h00);
    endtask

    task automatic t_qpi();
        logic [7:0] b;
        qpi_en = 1'b1;
        tick(4);
        send_enable(2);
        send_write(8'h01, 8'h5C, 2);
        read_status(8'h05, b); check8("R10 nibble read while busy", b, 8'h5F);
        check8("R10 four-line oe", {4'h0, last_oe}, 8'h0F);
        wait_cycle();
        read_status(8'h05, b); check8("R10 nibble write result", b, 8'h5C);
        send_enable(2);
        send_write(8'h01, 8'h00, 1);
        read_status(8'h05, b); check8("R10 R5 three-nibble write discarded", b, 8'h5E);
        qpi_en = 1'b0;
        tick(4);
    endtask

    initial begin
        last_oe = 4'h0;
        tick(5);
        rst_n = 1'b1;
        tick(5);
        t_reset();
        t_no_latch();
        t_enable_counts();
        t_bad_count();
        t_write_low_and_poll();
        t_all_ones();
        t_busy_ignore();
        t_hw_protect();
        t_qpi();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule